// File: doc/BRIEF.md
# Home-Computer 64K Address Decoder

This block sits between an 8-bit CPU's 16-bit address bus and three memories: a 16K ROM, a 16K RAM shared with the display fetcher, and a 32K general-purpose RAM. Address bit 15 splits the map into a lower and an upper half. The lower half is split again by bit 14: ROM at the bottom, shared RAM above it. The whole upper half is general RAM. For each memory cycle the block raises at most one chip select. It also passes on the address offset that each RAM needs.

A peripheral can take the ROM out of the map by driving an external disable level high. That level is asynchronous to the CPU clock. It is synchronised through two flops and is only taken into the decode state between memory requests, so the map never changes in the middle of an access. When the CPU reads or writes the shared RAM while the display fetcher holds it, the block drops the CPU clock-enable. The enable stays low until the fetcher lets go.

Top module: `mem_decode64k`

## Requirements
- R1: A read (`mem_req`=1, `rd`=1) with address bits [15:14]=00 asserts `rom_sel` while the ROM is enabled. The ROM is enabled after reset.
- R2: Once the disable state has been taken up from a high `rom_off_pad`, `rom_sel` stays low for every address 0x0000–0x3FFF.
- R3: A read or write with address bits [15:14]=01 asserts `vram_sel`. `vram_ofs` equals address bits [13:0].
- R4: A read or write with address bit 15=1 asserts `gram_sel`. `gram_ofs` equals address bits [14:0].
- R5: While `mem_req` is low, no select is asserted and `cpu_clk_en` stays high.
- R6: A write into 0x0000–0x3FFF asserts no select, neither the ROM select nor either RAM select.
- R7: `cpu_clk_en` is low exactly when a read or write to 0x4000–0x7FFF coincides with `vid_busy`=1. A busy fetcher does not stall accesses to other ranges.
- R8: `cpu_clk_en` is high again in the first cycle in which `vid_busy` is low.
- R9: A change on `rom_off_pad` takes effect on the third rising clock edge. It is taken up only at an edge where `mem_req` is low. While `mem_req` is high, the previous ROM state is held.
- R10: At most one of `rom_sel`, `vram_sel` and `gram_sel` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| mem_req | input | 1 | Memory request, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rom_off_pad | input | 1 | Asynchronous external ROM disable, high removes ROM |
| vid_busy | input | 1 | Display fetcher is using the shared RAM |
| rom_sel | output | 1 | ROM chip select |
| vram_sel | output | 1 | Shared RAM chip select |
| gram_sel | output | 1 | General RAM chip select |
| vram_ofs | output | 14 | Offset within the shared RAM |
| gram_ofs | output | 15 | Offset within the general RAM |
| cpu_clk_en | output | 1 | CPU clock enable, low holds the CPU |

## Verification
The hardest case to reach from the ports is the timing of the ROM disable. Its effect appears only after the synchroniser latency, and a memory request that covers the capture edge blocks it. The bench raises the pad with requests idle and lets two edges pass. It then places a ROM read across the third edge, so the old map must still hold. Only after one more idle edge does it expect the ROM to have left the map. Stall release is probed by dropping `vid_busy` during a held shared-RAM access.

// File: rtl/mem_decode64k.sv
module mem_decode64k #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          mem_req,
  input  logic          rd,
  input  logic          wr,
  input  logic          rom_off_pad,
  input  logic          vid_busy,
  output logic          rom_sel,
  output logic          vram_sel,
  output logic          gram_sel,
  output logic [AW-3:0] vram_ofs,
  output logic [AW-2:0] gram_ofs,
  output logic          cpu_clk_en
);

  logic pad_s1, pad_s2, rom_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_s1    <= 1'b0;
      pad_s2    <= 1'b0;
      rom_off_q <= 1'b0;
    end else begin
      pad_s1 <= rom_off_pad;
      pad_s2 <= pad_s1;
      if (!mem_req) rom_off_q <= pad_s2;
    end
  end

  wire in_rom  = addr[AW-1:AW-2] == 2'b00;
  wire in_vram = addr[AW-1:AW-2] == 2'b01;
  wire in_gram = addr[AW-1];
  wire xfer    = mem_req && (rd || wr);

  assign rom_sel    = mem_req && rd && in_rom && !rom_off_q;
  assign vram_sel   = xfer && in_vram;
  assign gram_sel   = xfer && in_gram;
  assign vram_ofs   = addr[AW-3:0];
  assign gram_ofs   = addr[AW-2:0];
  assign cpu_clk_en = !(vram_sel && vid_busy);

  assert_onehot_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, vram_sel, gram_sel}));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !rom_sel && !vram_sel && !gram_sel && cpu_clk_en);

  assert_romwr_nosel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && wr && !rd && addr[AW-1:AW-2] == 2'b00) |-> !(rom_sel || vram_sel || gram_sel));

  assert_stall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> vid_busy && vram_sel);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_busy |-> cpu_clk_en);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_off_q) |-> !$past(mem_req));

endmodule

// File: tb/test_mem_decode64k.sv
module test_mem_decode64k;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mem_req = 1'b0, rd = 1'b0, wr = 1'b0, rom_off_pad = 1'b0, vid_busy = 1'b0;
  logic        rom_sel, vram_sel, gram_sel, cpu_clk_en;
  logic [13:0] vram_ofs;
  logic [14:0] gram_ofs;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mem_decode64k i_mem_decode64k (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .rd(rd), .wr(wr),
    .rom_off_pad(rom_off_pad), .vid_busy(vid_busy), .rom_sel(rom_sel),
    .vram_sel(vram_sel), .gram_sel(gram_sel), .vram_ofs(vram_ofs),
    .gram_ofs(gram_ofs), .cpu_clk_en(cpu_clk_en)
  );

  // {addr, req, rd, wr, busy, exp rom, vram, gram, clk_en}
  localparam logic [23:0] VEC [12] = '{
    {16'h0000, 4'b1100, 4'b1001},  // R1
    {16'h3FFF, 4'b1100, 4'b1001},  // R1
    {16'h4000, 4'b1100, 4'b0101},  // R3
    {16'h7FFF, 4'b1011, 4'b0100},  // R7
    {16'h5123, 4'b1101, 4'b0100},  // R7
    {16'h8000, 4'b1101, 4'b0011},  // R4 R7
    {16'hFFFF, 4'b1010, 4'b0011},  // R4
    {16'h2000, 4'b1010, 4'b0001},  // R6
    {16'h4000, 4'b0101, 4'b0001},  // R5
    {16'hC000, 4'b0100, 4'b0001},  // R5
    {16'h0000, 4'b0100, 4'b0001},  // R5
    {16'h6000, 4'b1001, 4'b0001}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic q, input logic r, input logic w, input logic b);
    @(negedge clk);
    addr = a; mem_req = q; rd = r; wr = w; vid_busy = b;
    #1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10 R1 reset state: ROM enabled
    drive(16'h1234, 1, 1, 0, 0);
    check("R1 reset rom_sel", rom_sel, 1);
    check("R10 reset other sels", {vram_sel, gram_sel}, 0);

    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][23:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      check($sformatf("R1-vec%0d sels/en", i), {rom_sel, vram_sel, gram_sel, cpu_clk_en}, VEC[i][3:0]);
      check($sformatf("R3 vec%0d vram_ofs", i), vram_ofs, VEC[i][21:8]);
      check($sformatf("R4 vec%0d gram_ofs", i), gram_ofs, VEC[i][22:8]);
    end

    // R8: release on the first low cycle of vid_busy
    drive(16'h4800, 1, 1, 0, 1);
    check("R8 stalled", cpu_clk_en, 0);
    drive(16'h4800, 1, 1, 0, 0);
    check("R8 release", cpu_clk_en, 1);
    check("R8 vram still selected", vram_sel, 1);

    // R9: pad raised with idle bus, two edges pass, third edge blocked by a request
    drive(16'h0000, 0, 0, 0, 0);
    rom_off_pad = 1'b1;
    @(posedge clk); @(posedge clk);
    drive(16'h0000, 1, 1, 0, 0);
    check("R9 held across busy edge", rom_sel, 1);
    @(posedge clk);
    #1;
    check("R9 still held", rom_sel, 1);
    drive(16'h0000, 0, 0, 0, 0);
    drive(16'h0000, 1, 1, 0, 0);
    check("R2 rom off at 0000", rom_sel, 0);
    drive(16'h3FFF, 1, 1, 0, 0);
    check("R2 rom off at 3FFF", rom_sel, 0);
    drive(16'h2AAA, 1, 1, 0, 1);
    check("R2 no sel, no stall", {rom_sel, vram_sel, gram_sel, cpu_clk_en}, 4'b0001);
    drive(16'h9000, 1, 1, 0, 0);
    check("R4 gram unaffected by rom off", gram_sel, 1);

    // R9: pad lowered, ROM comes back after three idle edges
    drive(16'h0000, 0, 0, 0, 0);
    rom_off_pad = 1'b0;
    repeat (3) @(posedge clk);
    drive(16'h0100, 1, 1, 0, 0);
    check("R9 rom back", rom_sel, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule